// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Flag Handshake

This block moves one byte at a time over a four-wire synchronous serial link and is reached through a small register bus with two locations: a data location and a status location. A mode input picks whether the port drives the serial clock itself (master) or follows a clock and select from outside (slave). A single shift register sends its top bit and collects the incoming line, so each byte written goes out while a byte comes in.

Software writes a byte to the data location. In master mode that write starts the exchange, and in slave mode it only preloads the byte that the next outside exchange will return. When eight bits have been exchanged, a completion flag rises and the received byte is latched into a one-entry read buffer. The flag is cleared by a fixed handshake: first read status while the flag is up, then access the data location. Two error conditions are reported. A data write during a transfer is a collision. A completion that arrives while the flag is still up is an overrun.

Top module: `spi_port`

## Requirements
- R1: In master mode (isMaster=1), a write to the data location (busAddr=0) while idle sends the written byte MSB first on mosiOut. sckOut idles low, each bit is driven before its rising edge, and misoIn is sampled on the rising edge.
- R2: When a byte exchange completes, the done flag (status bit 7, read at busAddr=1) becomes 1, in both master and slave mode.
- R3: The done flag clears only when a status read sees a flag set and is followed by a read or write of the data location. A data access without that earlier status read leaves the flag set.
- R4: The received byte is copied into the read buffer on the same edge that sets the done flag, and a read of the data location returns that buffer.
- R5: If an exchange completes while the done flag is still set, the buffer keeps the earlier byte and the new one is dropped. The overrun bit (status bit 5) is then set until the clear handshake completes.
- R6: A data write during a transfer does not change the shift register and sets the collision bit (status bit 6). That bit is cleared by the same handshake as the done flag.
- R7: In slave mode, a data write loads the shift register but starts no transfer: sckOut stays low and the busy bit stays 0. The loaded byte is shifted out on misoOut during the next outside exchange.
- R8: A slave whose data location has not been written since its last exchange sends back the byte it last received.
- R9: The busy bit (status bit 4) is 1 while a master transfer is in progress.
- R10: A slave ignores sckIn while ssN is high, and no completion occurs.
- R11: misoOe is 1 only in slave mode while the synchronized ssN is low, two clock edges after ssN falls. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | 1 selects master mode, 0 selects slave mode |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 1 | 0 selects the data location, 1 selects the status location |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data: the receive buffer or the status word |
| sckOut | output | 1 | Serial clock driven in master mode |
| mosiOut | output | 1 | Master serial data out |
| misoIn | input | 1 | Master serial data in |
| sckIn | input | 1 | Serial clock from outside in slave mode |
| ssN | input | 1 | Slave select, active low |
| mosiIn | input | 1 | Slave serial data in |
| misoOut | output | 1 | Slave serial data out |
| misoOe | output | 1 | Output enable for misoOut |

## Verification
The bench builds the port with DATA_W=8 and HALF_DIV=4, so one master byte takes 64 system clocks. With these values a second bus write lands well inside a running transfer, and two back-to-back transfers can finish before any handshake, which sets up a collision and an overrun. The bench acts as the outside slave in master mode and as the outside master in slave mode. It runs its own serial clock at a 12-clock period, slow enough for the port's two-flop synchronizers to see every edge. A per-clock model of the synchronized select checks the output enable on every cycle.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic load;     // place bus write data into the shift register
    logic start;    // begin a master transfer
    logic capture;  // copy the shift register into the read buffer
  } spiStrobe_t;

endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       isMaster,
  input  logic       busSel,
  input  logic       busWr,
  input  logic       busAddr,
  input  logic       busy,
  input  logic       done,
  output spiStrobe_t strobe,
  output logic       spif,
  output logic       wcol,
  output logic       ovr
);

  logic armed;
  logic dataAcc, dataWr, statRd, clearNow, collide;

  assign dataAcc  = busSel && (busAddr == ADDR_DATA);
  assign dataWr   = dataAcc && busWr;
  assign statRd   = busSel && !busWr && (busAddr == ADDR_STAT);
  assign clearNow = dataAcc && armed;
  assign collide  = dataWr && busy;

  always_comb begin
    strobe.load    = dataWr && !busy;
    strobe.start   = dataWr && !busy && isMaster;
    strobe.capture = done && !spif;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spif  <= 1'b0;
      wcol  <= 1'b0;
      ovr   <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (done)          spif <= 1'b1;
      else if (clearNow) spif <= 1'b0;

      if (done && spif)  ovr <= 1'b1;
      else if (clearNow) ovr <= 1'b0;

      if (collide)       wcol <= 1'b1;
      else if (clearNow) wcol <= 1'b0;

      if (statRd)        armed <= spif || wcol;
      else if (dataAcc)  armed <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  spiStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              ssN,
  input  logic              mosiIn,
  output logic              sckOut,
  output logic              mosiOut,
  output logic              misoOut,
  output logic              misoOe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxBuf
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int DIV_W = $clog2(HALF_DIV) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(HALF_DIV - 1);
  localparam int SYNC_N = 3;  // index 0: sck, 1: mosi, 2: ss

  logic [DATA_W-1:0] shiftReg, rxBufReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              rxBit, active, sckReg, sckPrev, doneReg;
  logic [SYNC_N-1:0] syncRaw, syncA, syncB, syncInit;

  assign syncRaw  = {ssN, mosiIn, sckIn};
  assign syncInit = {1'b1, 1'b0, 1'b0};

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_N; gi++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncA[gi] <= syncInit[gi];
          syncB[gi] <= syncInit[gi];
        end else begin
          syncA[gi] <= syncRaw[gi];
          syncB[gi] <= syncA[gi];
        end
      end
    end
  endgenerate

  logic sckSync, mosiSync, slvSel, sckRise, sckFall;
  assign sckSync  = syncB[0];
  assign mosiSync = syncB[1];
  assign slvSel   = ~syncB[2];
  assign sckRise  = sckSync & ~sckPrev;
  assign sckFall  = ~sckSync & sckPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBufReg <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
      rxBit    <= 1'b0;
      active   <= 1'b0;
      sckReg   <= 1'b0;
      sckPrev  <= 1'b0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      sckPrev <= sckSync;
      if (isMaster) begin
        if (active) begin
          if (divCnt == DIV_TOP) begin
            divCnt <= '0;
            sckReg <= ~sckReg;
            if (!sckReg) begin
              rxBit <= misoIn;
            end else begin
              shiftReg <= {shiftReg[DATA_W-2:0], rxBit};
              if (bitCnt == LAST_BIT) begin
                bitCnt  <= '0;
                active  <= 1'b0;
                doneReg <= 1'b1;
              end else begin
                bitCnt <= bitCnt + CNT_W'(1);
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
      end else begin
        if (!slvSel) begin
          bitCnt <= '0;
        end else if (sckRise) begin
          rxBit <= mosiSync;
        end else if (sckFall) begin
          shiftReg <= {shiftReg[DATA_W-2:0], rxBit};
          if (bitCnt == LAST_BIT) begin
            bitCnt  <= '0;
            doneReg <= 1'b1;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
      end
      if (strobe.load) begin
        shiftReg <= wrData;
        bitCnt   <= '0;
      end
      if (strobe.start) begin
        active <= 1'b1;
        divCnt <= '0;
        sckReg <= 1'b0;
      end
      if (strobe.capture) rxBufReg <= shiftReg;
    end
  end

  assign sckOut  = isMaster & sckReg;
  assign mosiOut = shiftReg[DATA_W-1];
  assign misoOut = shiftReg[DATA_W-1];
  assign misoOe  = ~isMaster & slvSel;
  assign busy    = isMaster ? active : (slvSel & ((bitCnt != '0) | sckSync));
  assign done    = doneReg;
  assign rxBuf   = rxBufReg;

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              ssN,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe
);

  spiStrobe_t        strobe;
  logic              busy, done, spif, wcol, ovr;
  logic [DATA_W-1:0] rxBuf, statusWord;

  spi_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busy(busy), .done(done), .strobe(strobe),
    .spif(spif), .wcol(wcol), .ovr(ovr)
  );

  spi_port_dp #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .strobe(strobe),
    .wrData(busWdata), .misoIn(misoIn), .sckIn(sckIn), .ssN(ssN),
    .mosiIn(mosiIn), .sckOut(sckOut), .mosiOut(mosiOut),
    .misoOut(misoOut), .misoOe(misoOe), .busy(busy), .done(done),
    .rxBuf(rxBuf)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[DATA_W-1] = spif;
    statusWord[DATA_W-2] = wcol;
    statusWord[DATA_W-3] = ovr;
    statusWord[DATA_W-4] = busy;
  end

  assign busRdata = (busAddr == ADDR_STAT) ? statusWord : rxBuf;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              isMaster,
  input logic              sckOut,
  input logic              misoOe,
  input logic              busSel,
  input logic              busWr,
  input logic              busAddr,
  input logic              busy,
  input logic              spif,
  input logic              wcol,
  input logic              ovr,
  input logic [DATA_W-1:0] rxBuf
);

  AST_SLAVE_NO_SCK: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |-> !sckOut); // R7

  AST_OE_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !isMaster); // R11

  AST_WCOL_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !busAddr && busy) |=> wcol); // R6

  AST_OVR_WITH_SPIF: assert property (@(posedge clk) disable iff (!rstN)
    ovr |-> spif); // R5

  AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rstN)
    spif |=> $stable(rxBuf)); // R5

  AST_SPIF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (spif && !(busSel && !busAddr)) |=> spif); // R3

endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster), .sckOut(sckOut),
  .misoOe(misoOe), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busy(busy), .spif(spif), .wcol(wcol), .ovr(ovr), .rxBuf(rxBuf)
);

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;

  localparam int DATA_W   = 8;
  localparam int HALF_DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b1;
  logic busSel = 1'b0, busWr = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic sckOut, mosiOut, misoOut, misoOe;
  logic sckIn = 1'b0, ssN = 1'b1, mosiIn = 1'b0;
  logic [7:0] misoShift = '0;
  logic misoIn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign misoIn = misoShift[7];

  spi_port #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_spi_port (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .busSel(busSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .sckOut(sckOut), .mosiOut(mosiOut),
    .misoIn(misoIn), .sckIn(sckIn), .ssN(ssN), .mosiIn(mosiIn),
    .misoOut(misoOut), .misoOe(misoOe)
  );

  // outside slave model for master mode
  logic [7:0] gotFromMaster = '0;
  int sckRises = 0;
  always @(posedge sckOut) begin
    gotFromMaster = {gotFromMaster[6:0], mosiOut};
    sckRises++;
  end
  always @(negedge sckOut) misoShift = {misoShift[6:0], 1'b0};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock model of the two-stage select synchronizer
  logic ssH1 = 1'b1, ssH2 = 1'b1;
  always @(posedge clk) begin
    ssH2 <= ssH1;
    ssH1 <= ssN;
    if (rstN) begin
      #3;
      check(misoOe === (!isMaster && !ssH2), "R11 misoOe", misoOe, (!isMaster && !ssH2));
      if (!isMaster) check(sckOut === 1'b0, "R7 sckOut idle", sckOut, 0);
    end
  end

  task automatic busAcc(input bit wr, input bit addr, input logic [7:0] wd, output logic [7:0] rd);
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = addr; busWdata = wd;
    #2 rd = busRdata;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic wrData(input logic [7:0] wd);
    logic [7:0] dummy;
    busAcc(1'b1, 1'b0, wd, dummy);
  endtask

  task automatic rdStat(output logic [7:0] rd);
    busAcc(1'b0, 1'b1, 8'h00, rd);
  endtask

  task automatic rdData(output logic [7:0] rd);
    busAcc(1'b0, 1'b0, 8'h00, rd);
  endtask

  task automatic extByte(input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 0; i--) begin
      mosiIn = tx[i];
      repeat (6) @(negedge clk);
      sckIn = 1'b1;
      rx = {rx[6:0], misoOut};
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin : main
    logic [7:0] r;
    int riseMark;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    rdStat(r);  check(r == 8'h00, "R2 reset status", r, 8'h00);
    check(sckOut == 1'b0, "R1 sck idle low", sckOut, 0);

    // master exchange
    misoShift = 8'h3C;
    wrData(8'hA5);
    repeat (10) @(negedge clk);
    rdStat(r);  check(r == 8'h10, "R9 busy during transfer", r, 8'h10);
    repeat (90) @(negedge clk);
    check(gotFromMaster == 8'hA5, "R1 byte on mosi", gotFromMaster, 8'hA5);
    rdStat(r);  check(r == 8'h80, "R2 done flag master", r, 8'h80);
    rdData(r);  check(r == 8'h3C, "R4 buffer read", r, 8'h3C);
    rdStat(r);  check(r == 8'h00, "R3 flag cleared", r, 8'h00);

    // data access without a status read first
    misoShift = 8'hC3;
    wrData(8'h5A);
    repeat (100) @(negedge clk);
    rdData(r);  check(r == 8'hC3, "R4 buffer second byte", r, 8'hC3);
    rdStat(r);  check(r == 8'h80, "R3 no clear without status read", r, 8'h80);
    rdData(r);
    rdStat(r);  check(r == 8'h00, "R3 cleared after sequence", r, 8'h00);

    // collision
    misoShift = 8'hF0;
    wrData(8'h0F);
    repeat (10) @(negedge clk);
    wrData(8'hFF);
    repeat (100) @(negedge clk);
    check(gotFromMaster == 8'h0F, "R6 shift register untouched", gotFromMaster, 8'h0F);
    rdStat(r);  check(r == 8'hC0, "R6 collision bit", r, 8'hC0);
    rdData(r);  check(r == 8'hF0, "R4 buffer after collision", r, 8'hF0);
    rdStat(r);  check(r == 8'h00, "R6 collision cleared", r, 8'h00);

    // overrun
    misoShift = 8'h22;
    wrData(8'h11);
    repeat (100) @(negedge clk);
    misoShift = 8'h44;
    wrData(8'h33);
    repeat (100) @(negedge clk);
    rdStat(r);  check(r == 8'hA0, "R5 overrun bit", r, 8'hA0);
    rdData(r);  check(r == 8'h22, "R5 first byte kept", r, 8'h22);
    rdStat(r);  check(r == 8'h00, "R5 overrun cleared", r, 8'h00);

    // slave mode: write must not start anything
    @(negedge clk); isMaster = 1'b0;
    riseMark = sckRises;
    wrData(8'h96);
    repeat (30) @(negedge clk);
    check(sckRises == riseMark, "R7 no clock in slave", sckRises - riseMark, 0);
    rdStat(r);  check(r == 8'h00, "R7 not busy after slave write", r, 8'h00);

    ssN = 1'b0;
    repeat (5) @(negedge clk);
    extByte(8'h4E, r);
    check(r == 8'h96, "R7 preloaded byte out", r, 8'h96);
    rdStat(r);  check(r == 8'h80, "R2 done flag slave", r, 8'h80);
    rdData(r);  check(r == 8'h4E, "R4 slave buffer", r, 8'h4E);

    extByte(8'h81, r);
    check(r == 8'h4E, "R8 echo of last byte", r, 8'h4E);
    rdStat(r);
    rdData(r);  check(r == 8'h81, "R4 slave second byte", r, 8'h81);
    rdStat(r);  check(r == 8'h00, "R3 slave cleared", r, 8'h00);

    // deselected: clock ignored
    ssN = 1'b1;
    repeat (5) @(negedge clk);
    extByte(8'h77, r);
    rdStat(r);  check(r == 8'h00, "R10 no completion when deselected", r, 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule